// File: doc/BRIEF.md
# Bus Master Latency Timer

This block bounds how long a bus initiator may hold a burst-capable bus once it owns it. The host programs an 8-bit latency value through a simple write port and can read it back at any time. When the initiator asserts its frame signal, the block loads that value into a down counter and then counts one step per bus clock.

When the count reaches zero while the transaction is still running, the block raises a terminate request level. The request does not stop the transfer at once. It stays up until the master state machine reports the next completed data phase. At that point the block gives a one-cycle "end now" pulse that tells the master to close the transaction. A normal end of the transaction stops the counter and cancels any pending request. A new frame assertion reloads the counter from the register, so a write made during a transaction only affects the next one. A value of at least 20h is advisable so that most transactions can finish before the limit.

Top module: `bus_latency_timer`

## Requirements
- R1: After reset the latency register reads 00h, and `term_req` and `end_now` are both low.
- R2: The latency register is 8 bits wide and every bit is writable. A value written with `cfg_wr_en` high appears on `cfg_rd_data` from the next cycle onwards.
- R3: A frame start is a clock edge at which `frame` is sampled high after being sampled low at the edge before. At a frame start the counter loads the register value V. `term_req` goes high right after the V-th rising clock edge that follows the frame start, when no other event intervenes.
- R4: With V = 00h, `term_req` is high right after the frame start edge itself.
- R5: Once high, `term_req` holds, and the counter does not wrap, until a data phase completes, the transaction ends, or a new frame starts. A `phase_done` sampled before expiry has no effect.
- R6: When `phase_done` is sampled high while `term_req` is high, `end_now` is high for exactly the following cycle and `term_req` is low in that same cycle.
- R7: A sampled `xfer_done` stops the counter. After it, `term_req` stays low and `end_now` does not pulse. This holds even when `phase_done` is high in the same cycle.
- R8: A register write made during an active transaction does not change the running count. The new value is loaded at the next frame start. A write in the same cycle as a frame start loads the old value.
- R9: A new frame start during an active count reloads the counter from the register, and the expiry time restarts from that frame start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock; one count unit per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Latency register write strobe |
| cfg_wr_data | input | 8 | Latency value to write |
| cfg_rd_data | output | 8 | Current latency register value |
| frame | input | 1 | Initiator frame level; a rising edge starts the count |
| phase_done | input | 1 | Strobe: a data phase completed in this cycle |
| xfer_done | input | 1 | Strobe: the transaction ended normally in this cycle |
| term_req | output | 1 | Level: the latency limit has expired for the running transaction |
| end_now | output | 1 | One-cycle pulse: the master must end the transaction now |

## Verification
The assertions assume that `phase_done` and `xfer_done` are single-cycle strobes. They also assume that `frame` drops between transactions, so that each transaction produces exactly one frame start. The expiry-hold property further assumes that no frame start arrives while a request is pending. The stimulus keeps within these limits: every strobe is driven for one cycle, and `frame` is lowered before each new transaction. The only reload inside a transaction is the deliberate one, which happens before expiry.

// File: rtl/ltmr_pkg.sv
package ltmr_pkg;
    // Width of the latency register and the down counter.
    localparam int unsigned LTMR_W = 8;
    typedef logic [LTMR_W-1:0] lat_t;

    // Counter state: running flag plus remaining count.
    typedef struct packed {
        logic active;
        lat_t cnt;
    } cnt_state_t;

    // Terminate control state: registered end pulse.
    typedef struct packed {
        logic end_pulse;
    } term_state_t;
endpackage

// File: rtl/ltmr_cfg_reg.sv
module ltmr_cfg_reg
    import ltmr_pkg::*;
#(
    parameter lat_t RST_VAL = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  lat_t wr_data,
    output lat_t value
);
    lat_t val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) val_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= RST_VAL;
        else        val_q <= val_d;
    end

    assign value = val_q;

    // A write is visible on the next cycle.
    assert_write_visible_R2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (value == $past(wr_data)));
    // Without a write the value holds.
    assert_value_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value));
endmodule

// File: rtl/ltmr_frame_edge.sv
module ltmr_frame_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic frame,
    output logic start
);
    logic seen_d, seen_q;

    always_comb begin
        seen_d = frame;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= 1'b0;
        else        seen_q <= seen_d;
    end

    assign start = frame && !seen_q;

    // A frame start cannot occur on two consecutive cycles.
    assert_single_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !start);
endmodule

// File: rtl/ltmr_counter.sv
module ltmr_counter
    import ltmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  lat_t load_val,
    input  logic stop,
    output logic expired
);
    cnt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.active = 1'b1;
            st_d.cnt    = load_val;
        end else if (stop) begin
            st_d.active = 1'b0;
        end else if (st_q.active && (st_q.cnt != '0)) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign expired = st_q.active && (st_q.cnt == '0);

    // A frame start loads the programmed value and marks the counter running.
    assert_load_on_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (st_q.active && (st_q.cnt == $past(load_val))));
    // A running nonzero count steps down by one per cycle.
    assert_count_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.active && (st_q.cnt != '0) && !start && !stop)
        |=> (st_q.cnt == $past(st_q.cnt) - 1'b1));
    // A stop with no new frame leaves the counter idle.
    assert_stop_idles_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (stop && !start) |=> !st_q.active);
endmodule

// File: rtl/ltmr_term_ctrl.sv
module ltmr_term_ctrl
    import ltmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic expired,
    input  logic phase_done,
    input  logic xfer_done,
    input  logic start,
    output logic stop,
    output logic end_now
);
    term_state_t st_d, st_q;
    logic        fire;

    // End the transaction at a completed data phase after expiry, unless it
    // already ended normally or a new frame is starting.
    assign fire = expired && phase_done && !xfer_done && !start;
    assign stop = xfer_done || fire;

    always_comb begin
        st_d           = st_q;
        st_d.end_pulse = fire;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign end_now = st_q.end_pulse;

    // The end pulse lasts one cycle.
    assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_now |=> !end_now);
    // The request level is gone while the end pulse is out.
    assert_req_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
        end_now |-> !expired);
    // A normal end never produces an end pulse.
    assert_normal_end_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        xfer_done |=> !end_now);
    // A data phase before expiry has no effect.
    assert_early_phase_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_done && !expired) |=> !end_now);
endmodule

// File: rtl/bus_latency_timer.sv
module bus_latency_timer
    import ltmr_pkg::*;
#(
    parameter lat_t RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr_en,
    input  logic [LTMR_W-1:0] cfg_wr_data,
    output logic [LTMR_W-1:0] cfg_rd_data,
    input  logic              frame,
    input  logic              phase_done,
    input  logic              xfer_done,
    output logic              term_req,
    output logic              end_now
);
    lat_t lat_val;
    logic start;
    logic stop;
    logic expired;

    ltmr_cfg_reg #(.RST_VAL(RST_VAL)) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_wr_en),
        .wr_data (cfg_wr_data),
        .value   (lat_val)
    );

    ltmr_frame_edge u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .frame (frame),
        .start (start)
    );

    ltmr_counter u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .load_val (lat_val),
        .stop     (stop),
        .expired  (expired)
    );

    ltmr_term_ctrl u_term (
        .clk        (clk),
        .rst_n      (rst_n),
        .expired    (expired),
        .phase_done (phase_done),
        .xfer_done  (xfer_done),
        .start      (start),
        .stop       (stop),
        .end_now    (end_now)
    );

    assign cfg_rd_data = lat_val;
    assign term_req    = expired;

    // An expired request holds until a data phase, a normal end or a new frame.
    assert_req_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req && !phase_done && !xfer_done && !start) |=> term_req);
    // A request with a completed data phase produces the end pulse next cycle.
    assert_phase_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (term_req && phase_done && !xfer_done && !start) |=> (end_now && !term_req));
    // Reset state.
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |-> (!term_req && !end_now));
endmodule

// File: tb/tb_bus_latency_timer.sv
`timescale 1ns/1ps
module tb_bus_latency_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr_en = 1'b0;
    logic [7:0] cfg_wr_data = '0;
    logic [7:0] cfg_rd_data;
    logic       frame = 1'b0;
    logic       phase_done = 1'b0;
    logic       xfer_done = 1'b0;
    logic       term_req;
    logic       end_now;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    bus_latency_timer dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .frame       (frame),
        .phase_done  (phase_done),
        .xfer_done   (xfer_done),
        .term_req    (term_req),
        .end_now     (end_now)
    );

    typedef struct packed {
        logic [7:0] lat;
        logic [9:0] cyc;
    } vec_t;

    // Programmed value and the number of cycles from frame drive to term_req.
    localparam vec_t VECS [7] = '{
        '{8'h00, 10'd1},
        '{8'h01, 10'd2},
        '{8'h02, 10'd3},
        '{8'h07, 10'd8},
        '{8'h20, 10'd33},
        '{8'h03, 10'd4},
        '{8'hFF, 10'd256}
    };

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] v);
        cfg_wr_en   = 1'b1;
        cfg_wr_data = v;
        @(negedge clk);
        cfg_wr_en   = 1'b0;
    endtask

    // Count cycles until term_req rises; flags any end pulse on the way.
    task automatic wait_term(input int n0, input string req, output int n);
        n = n0;
        while (!term_req && n < 400) begin
            @(negedge clk);
            n++;
            if (end_now) check({req, " no end pulse before expiry"}, 1, 0);
        end
    endtask

    task automatic finish_by_phase(input string req);
        check({req, " end_now low before phase"}, int'(end_now), 0);
        phase_done = 1'b1;
        @(negedge clk);
        phase_done = 1'b0;
        check({req, " end_now pulse"}, int'(end_now), 1);
        check({req, " term_req dropped"}, int'(term_req), 0);
        @(negedge clk);
        check({req, " end_now single cycle"}, int'(end_now), 0);
        frame = 1'b0;
        @(negedge clk);
    endtask

    task automatic end_normal();
        xfer_done = 1'b1;
        @(negedge clk);
        xfer_done = 1'b0;
        frame     = 1'b0;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1 readback after reset", int'(cfg_rd_data), 0);
        check("R1 term_req after reset", int'(term_req), 0);
        check("R1 end_now after reset", int'(end_now), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: every bit writable
        wr(8'hA5);
        check("R2 readback A5", int'(cfg_rd_data), 8'hA5);
        wr(8'h5A);
        check("R2 readback 5A", int'(cfg_rd_data), 8'h5A);

        // Vector walk: R3 and R4 expiry timing, R6 end pulse
        for (int i = 0; i < 7; i++) begin
            wr(VECS[i].lat);
            frame = 1'b1;
            wait_term(0, "R3", n);
            check((VECS[i].lat == 8'h00) ? "R4 zero value expiry" : "R3 expiry cycle",
                  n, int'(VECS[i].cyc));
            finish_by_phase("R6");
        end

        // R5: early phase has no effect; request holds without a phase
        wr(8'h06);
        frame = 1'b1;
        @(negedge clk);
        phase_done = 1'b1;
        @(negedge clk);
        phase_done = 1'b0;
        check("R5 no pulse on early phase", int'(end_now), 0);
        wait_term(2, "R5", n);
        check("R5 expiry unchanged by early phase", n, 7);
        repeat (5) @(negedge clk);
        check("R5 request holds", int'(term_req), 1);
        check("R5 no pulse while holding", int'(end_now), 0);
        finish_by_phase("R5");

        // R7: normal end before expiry stops the counter
        wr(8'h0A);
        frame = 1'b1;
        repeat (3) @(negedge clk);
        end_normal();
        n = 0;
        for (int k = 0; k < 15; k++) begin
            @(negedge clk);
            if (term_req || end_now) n++;
        end
        check("R7 idle after normal end", n, 0);

        // R7: normal end and phase together after expiry
        wr(8'h01);
        frame = 1'b1;
        wait_term(0, "R7", n);
        phase_done = 1'b1;
        xfer_done  = 1'b1;
        @(negedge clk);
        phase_done = 1'b0;
        xfer_done  = 1'b0;
        check("R7 no pulse when normal end wins", int'(end_now), 0);
        check("R7 request cleared", int'(term_req), 0);
        frame = 1'b0;
        @(negedge clk);

        // R8: write during a transaction affects only the next one
        wr(8'h04);
        frame = 1'b1;
        repeat (2) @(negedge clk);
        wr(8'h14);
        wait_term(3, "R8", n);
        check("R8 running count uses old value", n, 5);
        end_normal();
        check("R8 readback new value", int'(cfg_rd_data), 8'h14);
        frame = 1'b1;
        wait_term(0, "R8", n);
        check("R8 next frame uses new value", n, 21);
        end_normal();

        // R8: write at the frame start loads the old value
        wr(8'h02);
        frame = 1'b1;
        wr(8'h09);
        wait_term(1, "R8", n);
        check("R8 same-cycle write loads old value", n, 3);
        end_normal();

        // R9: new frame start reloads the counter
        wr(8'h06);
        frame = 1'b1;
        repeat (3) @(negedge clk);
        frame = 1'b0;
        @(negedge clk);
        check("R9 not expired before reload", int'(term_req), 0);
        frame = 1'b1;
        wait_term(0, "R9", n);
        check("R9 expiry restarts at new frame", n, 7);
        finish_by_phase("R9");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule